// File: doc/BRIEF.md
# Two-Wire PHY Register Access Sequencer

This block lets a management agent read and write 16-bit registers of a PHY that can only be reached over a two-wire serial bus. The PHY answers at one fixed bus address and is reached through a pointer. The caller presents a register number, a direction, the write data and a one-cycle start strobe. The block then runs the complete bus transaction by itself. When the transaction ends it returns the read word, a one-cycle done pulse and an error flag that reports a missing acknowledge.

The two bus lines are open-drain. The block only decides when each line is pulled low, and an external pull-up supplies the high level. Bit timing comes from a quarter-bit divider. Each bit is four quarters long: SCL is low for the first two quarters and released for the last two. Every access has the same fixed shape. A write runs as one transaction. A read first writes the pointer and then reads the data back after a repeated START. Retries, several masters on one bus and clock stretching are left to the surrounding logic.

Top module: `phy_twowire_access`

## Requirements
- R1: The first byte after every START or repeated START is the 7-bit device address 0x56 followed by a direction bit: 0xAC for write direction and 0xAD for read direction.
- R2: The byte sent after the write-direction address is the register pointer. Its upper three bits are 000 and its lower five bits are the register number, so register 31 gives 0x1F.
- R3: A write access is a single transaction: START, 0xAC, pointer, high data byte, low data byte, STOP. It contains exactly one START condition and one STOP condition.
- R4: A read access is: START, 0xAC, pointer, repeated START, 0xAD, two data bytes, STOP. The returned word on `rdData` is the high received byte concatenated with the low received byte.
- R5: In both directions the high byte of the 16-bit word is moved first. Within each byte the most significant bit comes first.
- R6: During a read the block acknowledges the first data byte (SDA low in the ninth bit). It does not acknowledge the second (SDA released in the ninth bit).
- R7: If the device does not acknowledge an address byte, the pointer or a write-data byte, the access stops sending bytes and issues STOP. `done` then pulses with `nackErr` high. `nackErr` holds until the next accepted start strobe clears it.
- R8: `busy` rises in the cycle after an accepted start strobe. It stays high without a break until the cycle in which `done` pulses, and it is low in that cycle. A start strobe that arrives while `busy` is high has no effect on the bus or on the result.
- R9: SDA changes while SCL is released only for START, repeated START and STOP. Out of reset and whenever `busy` is low, both lines are released.
- R10: Within a byte, consecutive SCL rising edges are 4*QUARTER clock cycles apart, and every SCL high period lasts at least 2*QUARTER cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cmdStart | input | 1 | One-cycle request to begin an access |
| cmdWrite | input | 1 | 1 = register write, 0 = register read |
| cmdReg | input | REG_W | Register number |
| cmdWrData | input | 16 | Word to write |
| sdaIn | input | 1 | Resolved level of the SDA line |
| rdData | output | 16 | Word returned by the last successful read |
| done | output | 1 | One-cycle pulse at the end of an access |
| nackErr | output | 1 | The last access lost an acknowledge |
| busy | output | 1 | An access is in progress |
| sclOe | output | 1 | 1 pulls SCL low |
| sdaOe | output | 1 | 1 pulls SDA low |

## Verification
The hardest cases to reach from the ports are an acknowledge that goes missing partway through an access, and a second start strobe that arrives while the bus is busy. The bench holds a device model on the open-drain lines, and that model can withhold the acknowledge on a chosen byte of the transaction. This lets a failure be placed on the address byte or on a data byte in the middle of a write, and the bench then confirms that the stored register is left untouched. For the ignored strobe, the bench raises a write request partway through a read. It then checks that the bus shows only the read's START, repeated START and STOP, and that the target register of the write is unchanged.

// File: rtl/phy2w_pkg.sv
package phy2w_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;
  localparam logic [6:0] DEV_ADDR = 7'h56;

  // one-cycle strobes from sequencer to bit path
  typedef struct packed {
    logic             start;   // START or repeated START
    logic             stop;
    logic             wr;      // shift a byte out, sample device ack
    logic             rd;      // shift a byte in, drive our ack bit
    logic [BYTE_W-1:0] txByte;
    logic             nackOut; // for rd: 1 = release SDA in ninth bit
  } busCmd_t;

  typedef enum logic [1:0] {OP_IDLE, OP_COND_S, OP_COND_P, OP_XFER} busOp_t;

  typedef enum logic [3:0] {
    ST_IDLE, ST_START, ST_ADDRW, ST_PTR, ST_WHI, ST_WLO,
    ST_RSTART, ST_ADDRR, ST_RHI, ST_RLO, ST_STOP
  } seqState_t;
endpackage

// File: rtl/phy2w_bitpath.sv
module phy2w_bitpath
  import phy2w_pkg::*;
#(
  parameter int QUARTER = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  busCmd_t           cmd,
  input  logic              sdaIn,
  output logic              sclOe,
  output logic              sdaOe,
  output logic              opDone,
  output logic              ackSeen,
  output logic [BYTE_W-1:0] rxByte
);
  localparam int QW = (QUARTER > 1) ? $clog2(QUARTER) : 1;
  localparam logic [QW-1:0] QLAST = QW'(QUARTER - 1);
  localparam logic [3:0] ACK_BIT = 4'(BYTE_W);

  busOp_t            op;
  logic              isRead, nackOut;
  logic [1:0]        phase;
  logic [QW-1:0]     qCnt;
  logic [3:0]        bitIdx;
  logic [BYTE_W-1:0] txSh, rxSh;
  logic              sclHigh, sdaHigh;
  logic              sclNext, sdaNext, bitVal, tick, bitEnd;

  assign tick   = (op != OP_IDLE) && (qCnt == QLAST);
  assign bitEnd = tick && (phase == 2'd3);
  assign sclOe  = !sclHigh;
  assign sdaOe  = !sdaHigh;

  always_comb begin
    if (bitIdx == ACK_BIT) bitVal = isRead ? nackOut : 1'b1;
    else                   bitVal = isRead ? 1'b1 : txSh[BYTE_W-1];
  end

  // SCL high in quarters 2..3; SDA holds in quarter 0, moves in quarter 1
  always_comb begin
    sclNext = sclHigh;
    sdaNext = sdaHigh;
    if (op != OP_IDLE) begin
      sclNext = phase[1];
      if (phase != 2'd0) begin
        case (op)
          OP_COND_S: sdaNext = (phase != 2'd3);
          OP_COND_P: sdaNext = (phase == 2'd3);
          default:   sdaNext = bitVal;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      op <= OP_IDLE; isRead <= 1'b0; nackOut <= 1'b0;
      phase <= '0; qCnt <= '0; bitIdx <= '0;
      txSh <= '0; rxSh <= '0; rxByte <= '0;
      sclHigh <= 1'b1; sdaHigh <= 1'b1;
      opDone <= 1'b0; ackSeen <= 1'b0;
    end else begin
      opDone  <= 1'b0;
      sclHigh <= sclNext;
      sdaHigh <= sdaNext;
      if (op == OP_IDLE) begin
        phase <= '0; qCnt <= '0; bitIdx <= '0;
        if (cmd.start)     op <= OP_COND_S;
        else if (cmd.stop) op <= OP_COND_P;
        else if (cmd.wr || cmd.rd) begin
          op      <= OP_XFER;
          isRead  <= cmd.rd;
          txSh    <= cmd.txByte;
          nackOut <= cmd.nackOut;
        end
      end else begin
        qCnt <= tick ? '0 : qCnt + 1'b1;
        if (tick) phase <= phase + 2'd1;
        if (tick && phase == 2'd2 && op == OP_XFER) begin
          if (bitIdx < ACK_BIT) rxSh <= {rxSh[BYTE_W-2:0], sdaIn};
          else                  ackSeen <= !sdaIn;
        end
        if (bitEnd) begin
          if (op != OP_XFER || bitIdx == ACK_BIT) begin
            op     <= OP_IDLE;
            opDone <= 1'b1;
            rxByte <= rxSh;
          end else begin
            bitIdx <= bitIdx + 4'd1;
            txSh   <= {txSh[BYTE_W-2:0], 1'b0};
          end
        end
      end
    end
  end

  // R9: inside a byte, SDA never moves while SCL is released
  p_sda_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    (op == OP_XFER && $past(op) == OP_XFER && sclHigh && $past(sclHigh)) |-> $stable(sdaHigh));
  // R10: SCL stays low for a full half bit once pulled during a byte
  p_scl_low_half_r10: assert property (@(posedge clk) disable iff (!rstN)
    (op == OP_XFER && $past(op) == OP_XFER && $fell(sclHigh)) |=> !sclHigh);
  p_done_single_r8: assert property (@(posedge clk) disable iff (!rstN)
    opDone |=> !opDone);
endmodule

// File: rtl/phy2w_sequencer.sv
module phy2w_sequencer
  import phy2w_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdStart,
  input  logic              cmdWrite,
  input  logic [REG_W-1:0]  cmdReg,
  input  logic [WORD_W-1:0] cmdWrData,
  input  logic              opDone,
  input  logic              ackSeen,
  input  logic [BYTE_W-1:0] rxByte,
  output busCmd_t           cmd,
  output logic [WORD_W-1:0] rdData,
  output logic              done,
  output logic              nackErr,
  output logic              busy
);
  seqState_t         state;
  logic              launch, isWrite, errFlag, sendsByte;
  logic [REG_W-1:0]  regNum;
  logic [WORD_W-1:0] wrData;
  logic [BYTE_W-1:0] hiByte;

  assign sendsByte = state inside {ST_ADDRW, ST_PTR, ST_WHI, ST_WLO, ST_ADDRR};

  always_comb begin
    cmd = '0;
    if (launch) begin
      case (state)
        ST_START, ST_RSTART: cmd.start = 1'b1;
        ST_STOP:  cmd.stop = 1'b1;
        ST_ADDRW: begin cmd.wr = 1'b1; cmd.txByte = {DEV_ADDR, 1'b0}; end
        ST_ADDRR: begin cmd.wr = 1'b1; cmd.txByte = {DEV_ADDR, 1'b1}; end
        ST_PTR:   begin cmd.wr = 1'b1; cmd.txByte = BYTE_W'(regNum); end
        ST_WHI:   begin cmd.wr = 1'b1; cmd.txByte = wrData[WORD_W-1:BYTE_W]; end
        ST_WLO:   begin cmd.wr = 1'b1; cmd.txByte = wrData[BYTE_W-1:0]; end
        ST_RHI:   begin cmd.rd = 1'b1; cmd.nackOut = 1'b0; end
        ST_RLO:   begin cmd.rd = 1'b1; cmd.nackOut = 1'b1; end
        default:  cmd = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE; launch <= 1'b0; isWrite <= 1'b0; errFlag <= 1'b0;
      regNum <= '0; wrData <= '0; hiByte <= '0; rdData <= '0;
      nackErr <= 1'b0; busy <= 1'b0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (state == ST_IDLE) begin
        if (cmdStart) begin
          state <= ST_START; launch <= 1'b1; busy <= 1'b1;
          errFlag <= 1'b0; nackErr <= 1'b0;
          isWrite <= cmdWrite; regNum <= cmdReg; wrData <= cmdWrData;
        end
      end else begin
        launch <= 1'b0;
        if (opDone) begin
          launch <= 1'b1;
          if (sendsByte && !ackSeen) begin
            errFlag <= 1'b1;
            state   <= ST_STOP;
          end else begin
            case (state)
              ST_START:  state <= ST_ADDRW;
              ST_ADDRW:  state <= ST_PTR;
              ST_PTR:    state <= isWrite ? ST_WHI : ST_RSTART;
              ST_WHI:    state <= ST_WLO;
              ST_WLO:    state <= ST_STOP;
              ST_RSTART: state <= ST_ADDRR;
              ST_ADDRR:  state <= ST_RHI;
              ST_RHI: begin hiByte <= rxByte; state <= ST_RLO; end
              ST_RLO: begin rdData <= {hiByte, rxByte}; state <= ST_STOP; end
              ST_STOP: begin
                state <= ST_IDLE; launch <= 1'b0; busy <= 1'b0;
                done <= 1'b1; nackErr <= errFlag;
              end
              default: state <= ST_IDLE;
            endcase
          end
        end
      end
    end
  end

  p_busy_ends_done_r8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);
  p_done_not_busy_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);
  p_busy_from_start_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(cmdStart));
  p_ignore_while_busy_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busy && cmdStart) |=> ($stable(regNum) && $stable(wrData) && $stable(isWrite)));
  p_err_with_done_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(nackErr) |-> done);
endmodule

// File: rtl/phy_twowire_access.sv
module phy_twowire_access
  import phy2w_pkg::*;
#(
  parameter int QUARTER = 4,
  parameter int REG_W   = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdStart,
  input  logic              cmdWrite,
  input  logic [REG_W-1:0]  cmdReg,
  input  logic [WORD_W-1:0] cmdWrData,
  input  logic              sdaIn,
  output logic [WORD_W-1:0] rdData,
  output logic              done,
  output logic              nackErr,
  output logic              busy,
  output logic              sclOe,
  output logic              sdaOe
);
  busCmd_t           busCmd;
  logic              opDone, ackSeen;
  logic [BYTE_W-1:0] rxByte;

  phy2w_sequencer #(.REG_W(REG_W)) u_seq (
    .clk(clk), .rstN(rstN), .cmdStart(cmdStart), .cmdWrite(cmdWrite),
    .cmdReg(cmdReg), .cmdWrData(cmdWrData), .opDone(opDone),
    .ackSeen(ackSeen), .rxByte(rxByte), .cmd(busCmd), .rdData(rdData),
    .done(done), .nackErr(nackErr), .busy(busy)
  );

  phy2w_bitpath #(.QUARTER(QUARTER)) u_bits (
    .clk(clk), .rstN(rstN), .cmd(busCmd), .sdaIn(sdaIn),
    .sclOe(sclOe), .sdaOe(sdaOe), .opDone(opDone),
    .ackSeen(ackSeen), .rxByte(rxByte)
  );

  // R9: bus released whenever no access is running
  p_lines_free_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!sclOe && !sdaOe));
endmodule

// File: tb/phy_twowire_access_tb.sv
`timescale 1ns/1ps
module phy_twowire_access_tb;
  localparam int Q = 4;
  localparam int TCLK = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdStart = 1'b0, cmdWrite = 1'b0;
  logic [4:0] cmdReg = '0;
  logic [15:0] cmdWrData = '0;
  logic [15:0] rdData;
  logic done, nackErr, busy, sclOe, sdaOe;
  logic sclLine, sdaLine;
  logic slvDrive = 1'b0;

  int checks = 0, errors = 0;

  assign sclLine = !sclOe;
  assign sdaLine = !(sdaOe || slvDrive);

  always #(TCLK/2) clk = ~clk;

  phy_twowire_access #(.QUARTER(Q), .REG_W(5)) u_dut (
    .clk(clk), .rstN(rstN), .cmdStart(cmdStart), .cmdWrite(cmdWrite),
    .cmdReg(cmdReg), .cmdWrData(cmdWrData), .sdaIn(sdaLine),
    .rdData(rdData), .done(done), .nackErr(nackErr), .busy(busy),
    .sclOe(sclOe), .sdaOe(sdaOe)
  );

  // ---------------- device model ----------------
  logic [15:0] regs [32];
  logic [7:0] tLog [8];
  int tCnt = 0, starts = 0, stops = 0, bitCnt = 0, byteNo = 0, sendIdx = 0;
  int nackAt = -1;
  logic [7:0] sh = '0, ptr = '0, curByte = '0;
  logic [15:0] wbuf = '0;
  logic rdDir = 1'b0, sending = 1'b0, pendSend = 1'b0, masterAck = 1'b1, nackHit = 1'b0;
  logic mAck [2];
  time tRise = 0;
  int minRise = 1000000, minHigh = 1000000;

  always @(negedge sdaLine) if (sclLine === 1'b1) begin
    starts++; bitCnt = 0; byteNo = 0; sending = 1'b0; pendSend = 1'b0; slvDrive = 1'b0;
  end

  always @(posedge sdaLine) if (sclLine === 1'b1) begin
    stops++; sending = 1'b0; slvDrive = 1'b0;
    if (!rdDir && byteNo == 4 && !nackHit) regs[ptr[4:0]] = wbuf;
  end

  always @(posedge sclLine) begin
    if (bitCnt < 8) sh = {sh[6:0], sdaLine};
    else masterAck = sdaLine;
    if (bitCnt < 9) bitCnt++;
    if (tRise != 0) minRise = (int'($time - tRise) < minRise) ? int'($time - tRise) : minRise;
    tRise = $time;
  end

  always @(negedge sclLine) begin
    if (tRise != 0) minHigh = (int'($time - tRise) < minHigh) ? int'($time - tRise) : minHigh;
    if (bitCnt == 8) begin
      if (sending) slvDrive = 1'b0;
      else begin
        logic ackIt;
        ackIt = (byteNo != nackAt) && !(byteNo == 0 && sh[7:1] != 7'h56);
        if (tCnt < 8) tLog[tCnt] = sh;
        tCnt++;
        if (!ackIt) nackHit = 1'b1;
        if (byteNo == 0) begin rdDir = sh[0]; pendSend = ackIt && sh[0]; end
        else if (!rdDir) begin
          if (byteNo == 1) ptr = sh;
          if (byteNo == 2) wbuf[15:8] = sh;
          if (byteNo == 3) wbuf[7:0] = sh;
        end
        byteNo++;
        slvDrive = ackIt;
      end
    end else if (bitCnt == 9) begin
      bitCnt = 0; slvDrive = 1'b0;
      if (pendSend) begin
        pendSend = 1'b0; sending = 1'b1; sendIdx = 0; curByte = regs[ptr[4:0]][15:8];
      end else if (sending) begin
        mAck[sendIdx] = masterAck;
        if (!masterAck && sendIdx == 0) begin sendIdx = 1; curByte = regs[ptr[4:0]][7:0]; end
        else sending = 1'b0;
      end
      if (sending) slvDrive = !curByte[7];
    end else if (sending && bitCnt > 0 && bitCnt < 8) begin
      slvDrive = !curByte[7-bitCnt];
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clearLog();
    tCnt = 0; starts = 0; stops = 0; nackHit = 1'b0;
    mAck[0] = 1'b1; mAck[1] = 1'b0;
    for (int i = 0; i < 8; i++) tLog[i] = 8'h00;
  endtask

  task automatic waitDone(output int drops, output logic [15:0] rd, output logic err);
    int guard = 0;
    drops = 0;
    while (!done && guard < 20000) begin
      if (!busy) drops++;
      @(negedge clk); guard++;
    end
    if (guard >= 20000) begin
      errors++; checks++;
      $display("FAIL R8 watchdog: actual=no done expected=done");
    end
    rd = rdData; err = nackErr;
    repeat (3) @(negedge clk);
  endtask

  task automatic access(input logic wr, input logic [4:0] rn, input logic [15:0] wd,
                        output logic [15:0] rd, output logic err);
    int drops;
    clearLog();
    @(negedge clk);
    cmdStart = 1'b1; cmdWrite = wr; cmdReg = rn; cmdWrData = wd;
    @(negedge clk);
    cmdStart = 1'b0;
    waitDone(drops, rd, err);
    chk("R8 busy held until done", drops, 0);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    chk("R9 scl released after reset", sclOe, 0);
    chk("R9 sda released after reset", sdaOe, 0);
    chk("R8 busy low after reset", busy, 0);
    chk("R7 nackErr low after reset", nackErr, 0);
  endtask

  task automatic t_write();
    logic [15:0] rd; logic err;
    access(1'b1, 5'd5, 16'hBEEF, rd, err);
    chk("R1 write address byte", tLog[0], 8'hAC);
    chk("R2 pointer byte", tLog[1], 8'h05);
    chk("R5 high byte first", tLog[2], 8'hBE);
    chk("R5 low byte second", tLog[3], 8'hEF);
    chk("R3 write byte count", tCnt, 4);
    chk("R3 write single start", starts, 1);
    chk("R3 write one stop", stops, 1);
    chk("R3 register stored", regs[5], 16'hBEEF);
    chk("R7 no error on clean write", err, 0);
  endtask

  task automatic t_read(input logic [4:0] rn);
    logic [15:0] rd; logic err;
    access(1'b0, rn, 16'h0000, rd, err);
    chk("R1 first address write dir", tLog[0], 8'hAC);
    chk("R2 read pointer", tLog[1], 8'(rn));
    chk("R1 second address read dir", tLog[2], 8'hAD);
    chk("R4 bytes sent by master", tCnt, 3);
    chk("R4 start plus repeated start", starts, 2);
    chk("R4 one stop", stops, 1);
    chk("R4 read word", rd, regs[rn]);
    chk("R6 ack after first byte", mAck[0], 0);
    chk("R6 nack after second byte", mAck[1], 1);
    chk("R7 no error on clean read", err, 0);
  endtask

  task automatic t_timing();
    logic [15:0] rd; logic err;
    tRise = 0; minRise = 1000000; minHigh = 1000000;
    access(1'b0, 5'd12, 16'h0, rd, err);
    chk("R10 bit period", minRise, 4*Q*TCLK);
    chk("R10 scl high time", minHigh, 2*Q*TCLK);
    chk("R4 read mid register", rd, regs[12]);
  endtask

  task automatic t_nack_addr();
    logic [15:0] rd; logic err;
    nackAt = 0;
    access(1'b1, 5'd6, 16'h1357, rd, err);
    nackAt = -1;
    chk("R7 nack flag on address", err, 1);
    chk("R7 no byte after address", tCnt, 1);
    chk("R7 stop issued", stops, 1);
    chk("R7 flag held after done", nackErr, 1);
    chk("R7 register untouched", regs[6], 16'(6*16'h0101 + 16'h3000));
    t_read(5'd6);
    chk("R7 flag cleared by next access", nackErr, 0);
  endtask

  task automatic t_nack_data();
    logic [15:0] rd; logic err;
    nackAt = 2;
    access(1'b1, 5'd9, 16'hCAFE, rd, err);
    nackAt = -1;
    chk("R7 nack flag on data byte", err, 1);
    chk("R7 stop after nacked byte", tCnt, 3);
    chk("R7 partial write discarded", regs[9], 16'(9*16'h0101 + 16'h3000));
  endtask

  task automatic t_busy_ignore();
    int drops; logic [15:0] rd; logic err;
    clearLog();
    @(negedge clk);
    cmdStart = 1'b1; cmdWrite = 1'b0; cmdReg = 5'd3; cmdWrData = 16'h0;
    @(negedge clk);
    cmdStart = 1'b0;
    chk("R8 busy after strobe", busy, 1);
    repeat (150) @(negedge clk);
    cmdStart = 1'b1; cmdWrite = 1'b1; cmdReg = 5'd7; cmdWrData = 16'h1234;
    @(negedge clk);
    cmdStart = 1'b0;
    waitDone(drops, rd, err);
    chk("R8 busy held with extra strobe", drops, 0);
    chk("R8 first access result kept", rd, regs[3]);
    chk("R8 no extra transaction starts", starts, 2);
    chk("R8 no extra stop", stops, 1);
    chk("R8 ignored write left register", regs[7], 16'(7*16'h0101 + 16'h3000));
    chk("R8 idle after done", busy, 0);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) regs[i] = 16'(i*16'h0101 + 16'h3000);
    regs[0] = 16'h8001;
    regs[31] = 16'h7FFE;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_write();
    t_read(5'd5);
    t_read(5'd0);
    t_read(5'd31);
    t_timing();
    t_nack_addr();
    t_nack_data();
    t_busy_ignore();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(TCLK * 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule